// File: doc/BRIEF.md
# Window Framebuffer Fetch Address Generator

This block produces the memory read requests that pull one overlay window's pixels out of a linear framebuffer. Software programs a start byte address (already advanced to the crop origin), a page width giving the bytes fetched on each line, a line skip giving the bytes passed over between the end of one fetched line and the start of the next, an end address, and a pixel format code. On a frame start pulse the block captures that configuration and walks the window line by line in bursts. It never lets a burst run past the end of a line. When the walk reaches the end address it stops and raises a frame-done flag.

Requests leave on a valid/ready interface that carries a byte address and a burst length in bytes. The format code picks the burst length and the lane swap applied to returned data beats. The software side derives its values as follows:
- start = base + x*bpp + y*pitch
- page width = window width * bpp
- skip = (framebuffer width - window width) * bpp
- end = start + framebuffer width * window height * bpp

Memory arbitration, pixel unpacking and blending sit outside this block.

Top module: `win_fetch_agen`

## Requirements
- R1: After reset, `req_valid_o` and `frame_done_o` are both 0.
- R2: On the cycle after a `frame_start_i` pulse with a nonzero page width and start below end, a request is presented with `req_addr_o` equal to the start address. A presented request keeps its address and length unchanged until it is accepted (`req_valid_o && req_ready_i`) or a new frame starts.
- R3: Each request length equals the smaller of the format burst size and the bytes still unfetched in the current line. A burst never crosses a line end.
- R4: After the last burst of a line is accepted, the next address is the byte after that line plus the line skip. The next line again has the full page width.
- R5: When the next address would be at or beyond the end address, requests stop and `frame_done_o` goes to 1 and stays there until the next frame start. A frame start with page width 0 or start not below end gives `frame_done_o`=1 with no request.
- R6: Burst size by format code (`cfg_fmt_i`): code 0 (8 bpp palette) gives 32 bytes (8 words). Codes 1 and 2 (16 bpp 1555/565) give 64 bytes (16 words). Codes 3 and 4 (24/32 bpp) and all other codes give 64 bytes.
- R7: `rdata_o` is `rdata_i` with a lane swap chosen by the captured format. Code 0 reverses the order of all bytes of the beat. Codes 1 and 2 reverse the order of its 16-bit halfwords. All other codes reverse the order of its 32-bit words.
- R8: Configuration inputs are captured only at a frame start. Changes during a frame alter neither the request stream nor the data swap until the next frame start.
- R9: A frame start during an active frame abandons it. The next request is the new start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Single-cycle frame start pulse |
| cfg_start_addr_i | input | AW | First byte address of the window |
| cfg_end_addr_i | input | AW | Address bounding the frame |
| cfg_page_width_i | input | LW | Bytes fetched per line |
| cfg_line_skip_i | input | LW | Bytes skipped after each line |
| cfg_fmt_i | input | 3 | Pixel format code |
| req_valid_o | output | 1 | Burst request valid |
| req_ready_i | input | 1 | Burst request accepted |
| req_addr_o | output | AW | Burst start byte address |
| req_len_o | output | LW | Burst length in bytes |
| frame_done_o | output | 1 | Frame walk finished |
| rdata_i | input | DW | Returned data beat |
| rdata_o | output | DW | Lane-swapped data beat |

## Verification
A corrupted line counter shows up as a request length that crosses a page boundary, or as a line skip landing one burst early or late. Either is visible on the very next request after the faulty handshake. A wrong address register or a stale end compare shows as a wrong `req_addr_o`, or as `frame_done_o` rising before or after the exact request count the window needs. A configuration latch that follows its inputs mid-frame shows on the next presented request or on `rdata_o` in the same cycle as the write.

// File: rtl/win_fetch_pkg.sv
package win_fetch_pkg;
  typedef enum logic [2:0] {
    FMT_PAL8  = 3'd0,
    FMT_X1555 = 3'd1,
    FMT_R565  = 3'd2,
    FMT_X888  = 3'd3,
    FMT_A888  = 3'd4
  } pix_fmt_e;

  typedef enum logic [1:0] {
    SWP_BYTE = 2'd0,
    SWP_HALF = 2'd1,
    SWP_WORD = 2'd2
  } swap_e;

  localparam int unsigned WORD_BYTES = 4;

  function automatic swap_e fmt_swap(input logic [2:0] f);
    case (f)
      FMT_PAL8:            return SWP_BYTE;
      FMT_X1555, FMT_R565: return SWP_HALF;
      default:             return SWP_WORD;
    endcase
  endfunction

  function automatic logic fmt_short_burst(input logic [2:0] f);
    return f == FMT_PAL8;
  endfunction
endpackage

// File: rtl/win_fetch_cfg.sv
module win_fetch_cfg
  import win_fetch_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 16,
  parameter int unsigned SHORT_WORDS = 8,
  parameter int unsigned LONG_WORDS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] end_i,
  input  logic [LW-1:0] pw_i,
  input  logic [LW-1:0] skip_i,
  input  logic [2:0]    fmt_i,
  output logic [AW-1:0] end_o,
  output logic [LW-1:0] pw_o,
  output logic [LW-1:0] skip_o,
  output logic [LW-1:0] burst_o,
  output swap_e         swap_o
);
  localparam logic [LW-1:0] SHORT_BYTES = LW'(SHORT_WORDS * WORD_BYTES);
  localparam logic [LW-1:0] LONG_BYTES  = LW'(LONG_WORDS * WORD_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      end_o   <= '0;
      pw_o    <= '0;
      skip_o  <= '0;
      burst_o <= LONG_BYTES;
      swap_o  <= SWP_WORD;
    end else if (load_i) begin
      end_o   <= end_i;
      pw_o    <= pw_i;
      skip_o  <= skip_i;
      burst_o <= fmt_short_burst(fmt_i) ? SHORT_BYTES : LONG_BYTES;
      swap_o  <= fmt_swap(fmt_i);
    end
  end

  // R8: captured values move only on a frame start
  a_r8_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(end_o) && $stable(pw_o) && $stable(skip_o) &&
                 $stable(burst_o) && $stable(swap_o)));
endmodule

// File: rtl/win_fetch_walker.sv
module win_fetch_walker #(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_start_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] end_i,
  input  logic [LW-1:0] pw_i,
  input  logic [AW-1:0] lat_end_i,
  input  logic [LW-1:0] lat_pw_i,
  input  logic [LW-1:0] lat_skip_i,
  input  logic [LW-1:0] burst_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [LW-1:0] len_o,
  output logic          done_o
);
  logic [AW-1:0] cur_q;
  logic [LW-1:0] left_q;
  logic          active_q, done_q;
  logic          line_end;
  logic [AW-1:0] nxt;
  logic          start_ok;

  assign len_o    = (left_q < burst_i) ? left_q : burst_i;
  assign line_end = (len_o == left_q);
  assign nxt      = cur_q + AW'(len_o) + (line_end ? AW'(lat_skip_i) : '0);
  assign start_ok = (pw_i != '0) && (start_i < end_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q    <= '0;
      left_q   <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (frame_start_i) begin
      cur_q    <= start_i;
      left_q   <= pw_i;
      active_q <= start_ok;
      done_q   <= !start_ok;
    end else if (active_q && ready_i) begin
      cur_q  <= nxt;
      left_q <= line_end ? lat_pw_i : left_q - len_o;
      if (nxt >= lat_end_i) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end
    end
  end

  assign valid_o = active_q;
  assign addr_o  = cur_q;
  assign done_o  = done_q;

  // R2: an unaccepted request holds
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !frame_start_i) |=>
      (valid_o && $stable(addr_o) && $stable(len_o)));
  // R3: never empty, never past the line or the burst size
  a_r3_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (len_o != '0 && len_o <= burst_i && len_o <= left_q));
  // R5: a finished frame issues nothing
  a_r5_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o);
  // R9: a frame start always restarts at the start address
  a_r9_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && start_ok) |=> (valid_o && addr_o == $past(start_i)));
endmodule

// File: rtl/win_fetch_swap.sv
module win_fetch_swap
  import win_fetch_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  swap_e         mode_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o
);
  localparam int unsigned NB = DW / 8;
  localparam int unsigned NH = DW / 16;
  localparam int unsigned NW = DW / 32;

  logic [DW-1:0] by_byte, by_half, by_word;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign by_byte[i*8 +: 8] = data_i[(NB-1-i)*8 +: 8];
  end
  for (genvar i = 0; i < NH; i++) begin : g_half
    assign by_half[i*16 +: 16] = data_i[(NH-1-i)*16 +: 16];
  end
  for (genvar i = 0; i < NW; i++) begin : g_word
    assign by_word[i*32 +: 32] = data_i[(NW-1-i)*32 +: 32];
  end

  always_comb begin
    case (mode_i)
      SWP_BYTE: data_o = by_byte;
      SWP_HALF: data_o = by_half;
      default:  data_o = by_word;
    endcase
  end

  // R7: a lane permutation keeps every bit
  always_comb begin
    a_r7_perm: assert ($countones(data_o) == $countones(data_i));
  end
endmodule

// File: rtl/win_fetch_agen.sv
module win_fetch_agen
  import win_fetch_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 16,
  parameter int unsigned DW = 64,
  parameter int unsigned SHORT_WORDS = 8,
  parameter int unsigned LONG_WORDS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_start_i,
  input  logic [AW-1:0] cfg_start_addr_i,
  input  logic [AW-1:0] cfg_end_addr_i,
  input  logic [LW-1:0] cfg_page_width_i,
  input  logic [LW-1:0] cfg_line_skip_i,
  input  logic [2:0]    cfg_fmt_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic [AW-1:0] req_addr_o,
  output logic [LW-1:0] req_len_o,
  output logic          frame_done_o,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [AW-1:0] lat_end;
  logic [LW-1:0] lat_pw, lat_skip, burst;
  swap_e         swap;

  win_fetch_cfg #(
    .AW(AW), .LW(LW), .SHORT_WORDS(SHORT_WORDS), .LONG_WORDS(LONG_WORDS)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (frame_start_i),
    .end_i   (cfg_end_addr_i),
    .pw_i    (cfg_page_width_i),
    .skip_i  (cfg_line_skip_i),
    .fmt_i   (cfg_fmt_i),
    .end_o   (lat_end),
    .pw_o    (lat_pw),
    .skip_o  (lat_skip),
    .burst_o (burst),
    .swap_o  (swap)
  );

  win_fetch_walker #(.AW(AW), .LW(LW)) u_walk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .start_i       (cfg_start_addr_i),
    .end_i         (cfg_end_addr_i),
    .pw_i          (cfg_page_width_i),
    .lat_end_i     (lat_end),
    .lat_pw_i      (lat_pw),
    .lat_skip_i    (lat_skip),
    .burst_i       (burst),
    .ready_i       (req_ready_i),
    .valid_o       (req_valid_o),
    .addr_o        (req_addr_o),
    .len_o         (req_len_o),
    .done_o        (frame_done_o)
  );

  win_fetch_swap #(.DW(DW)) u_swap (
    .mode_i (swap),
    .data_i (rdata_i),
    .data_o (rdata_o)
  );

  // R1: idle out of reset
  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |=> (!req_valid_o && !frame_done_o));
endmodule

// File: tb/win_fetch_agen_test.sv
module win_fetch_agen_test;
  localparam int AW = 32, LW = 16, DW = 64;
  localparam int NV = 6;
  localparam int V_FMT  [NV] = '{0, 1, 2, 3, 4, 7};
  localparam int V_ST   [NV] = '{32'h1000, 32'h2002, 32'h3000, 32'h4000, 32'h5000, 32'h6001};
  localparam int V_PW   [NV] = '{100, 128, 40, 200, 64, 70};
  localparam int V_SKIP [NV] = '{28, 0, 24, 56, 0, 10};
  localparam int V_H    [NV] = '{3, 2, 4, 2, 1, 2};
  localparam int V_STALL[NV] = '{0, 0, 1, 0, 0, 1};
  localparam logic [DW-1:0] BEAT = 64'h0011223344556677;

  logic clk_i = 0, rst_ni = 0, frame_start_i = 0, req_ready_i = 0;
  logic [AW-1:0] cfg_start_addr_i = '0, cfg_end_addr_i = '0;
  logic [LW-1:0] cfg_page_width_i = '0, cfg_line_skip_i = '0;
  logic [2:0] cfg_fmt_i = '0;
  logic req_valid_o, frame_done_o;
  logic [AW-1:0] req_addr_o;
  logic [LW-1:0] req_len_o;
  logic [DW-1:0] rdata_i = BEAT, rdata_o;
  int errors = 0, checks = 0;

  always #10 clk_i = ~clk_i;

  win_fetch_agen uut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int burst_of(input int f);
    return (f == 0) ? 32 : 64;
  endfunction

  function automatic logic [DW-1:0] swap_of(input int f);
    if (f == 0) return 64'h7766554433221100;
    if (f == 1 || f == 2) return 64'h6677445522330011;
    return 64'h4455667700112233;
  endfunction

  task automatic pulse_frame(input int f, st, en, pw, sk);
    cfg_fmt_i = 3'(f); cfg_start_addr_i = AW'(st); cfg_end_addr_i = AW'(en);
    cfg_page_width_i = LW'(pw); cfg_line_skip_i = LW'(sk);
    frame_start_i = 1;
    @(negedge clk_i);
    frame_start_i = 0;
  endtask

  task automatic run_frame(input int f, st, pw, sk, h, bit stall);
    int ea, left, en, len, cyc;
    bit fin;
    en = st + (pw + sk) * h;
    req_ready_i = 0;
    pulse_frame(f, st, en, pw, sk);
    ea = st; left = pw; cyc = 0; fin = 0;
    while (!fin && cyc < 2000) begin
      len = (left < burst_of(f)) ? left : burst_of(f);
      chk(req_valid_o == 1, "R2 valid", 64'(req_valid_o), 1);
      chk(req_addr_o == AW'(ea), "R4 addr", 64'(req_addr_o), 64'(ea));
      chk(req_len_o == LW'(len), "R3/R6 len", 64'(req_len_o), 64'(len));
      req_ready_i = stall ? cyc[0] : 1'b1;
      if (req_ready_i) begin
        if (len == left) begin ea += len + sk; left = pw; end
        else begin ea += len; left -= len; end
        if (ea >= en) fin = 1;
      end
      @(negedge clk_i);
      cyc++;
    end
    req_ready_i = 0;
    chk(req_valid_o == 0 && frame_done_o == 1, "R5 end", {req_valid_o, frame_done_o}, 2'b01);
    chk(rdata_o == swap_of(f), "R7 swap", rdata_o, swap_of(f));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk(req_valid_o == 0 && frame_done_o == 0, "R1 reset", {req_valid_o, frame_done_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(req_valid_o == 0 && frame_done_o == 0, "R1 idle", {req_valid_o, frame_done_o}, 0);

    for (int v = 0; v < NV; v++)
      run_frame(V_FMT[v], V_ST[v], V_PW[v], V_SKIP[v], V_H[v], V_STALL[v] != 0);

    // R5 degenerate frames
    pulse_frame(3, 32'h700, 32'h800, 0, 0);
    chk(req_valid_o == 0 && frame_done_o == 1, "R5 zero width", {req_valid_o, frame_done_o}, 1);
    pulse_frame(3, 32'h800, 32'h800, 16, 0);
    chk(req_valid_o == 0 && frame_done_o == 1, "R5 empty range", {req_valid_o, frame_done_o}, 1);

    // R8 mid-frame writes ignored
    pulse_frame(0, 32'h100, 32'h180, 64, 0);
    cfg_start_addr_i = 32'h900; cfg_end_addr_i = 32'h908;
    cfg_page_width_i = 8; cfg_fmt_i = 3'd3;
    @(negedge clk_i);
    chk(req_addr_o == 32'h100, "R8 addr", 64'(req_addr_o), 64'h100);
    chk(req_len_o == 32, "R8 len", 64'(req_len_o), 32);
    chk(rdata_o == swap_of(0), "R8 swap", rdata_o, swap_of(0));
    req_ready_i = 1;
    for (int k = 0; k < 4; k++) begin
      chk(req_addr_o == AW'(32'h100 + 32 * k), "R8 walk", 64'(req_addr_o), 64'(32'h100 + 32 * k));
      @(negedge clk_i);
    end
    req_ready_i = 0;
    chk(frame_done_o == 1 && req_valid_o == 0, "R8 done", {req_valid_o, frame_done_o}, 1);

    // R9 restart mid-frame
    pulse_frame(3, 32'h400, 32'h500, 128, 0);
    req_ready_i = 1;
    @(negedge clk_i);
    req_ready_i = 0;
    chk(req_addr_o == 32'h440, "R9 advanced", 64'(req_addr_o), 64'h440);
    pulse_frame(3, 32'h400, 32'h500, 128, 0);
    chk(req_valid_o == 1 && req_addr_o == 32'h400, "R9 restart", 64'(req_addr_o), 64'h400);
    chk(frame_done_o == 0, "R9 not done", 64'(frame_done_o), 0);
    req_ready_i = 1;
    repeat (4) @(negedge clk_i);
    req_ready_i = 0;
    chk(frame_done_o == 1, "R9 done", 64'(frame_done_o), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule